// File: doc/BRIEF.md
# Operating-Mode and Direct-Page Control Registers

This block is a pair of byte-wide control registers on a simple single-cycle register bus. One holds the device operating mode (normal single-chip or special single-chip). The other holds the page base used by 8-bit direct addressing. While reset is held, the mode register tracks an external strap pin. The value present at reset release stays in effect afterwards.

Software writes are qualified by several rules. A mode write may only move from special to normal, and writing the current value is harmless. An attempt to go the other way sets a sticky lock. The lock blocks later mode writes unless the device is in special mode. A secured input blocks every mode write. The page register can be written freely in special mode, but only once per reset in normal mode.

The block forms the 16-bit direct address from the page base and an 8-bit operand. It also flags when a probe address falls inside the current direct page.

Top module: `mdp_ctrl`

## Requirements
- R1: While rst_n is low the mode output follows mode_pin, sampled on each clock edge. The value sampled at the last edge before release is kept after release.
- R2: The mode register is at offset 0x0B, with the mode at bit 7 (1 = normal, 0 = special). A write requesting normal while in special is accepted. A write requesting the current mode changes nothing and sets no lock.
- R3: While secured is high, every write to the mode register is ignored.
- R4: A write requesting special while in normal leaves the mode unchanged and sets a lock flag, which reads back at bit 6 of the mode register. The lock stays set until reset. While it is set, mode writes are ignored outside special mode.
- R5: The page register is at offset 0x11 and reads 0x00 after reset.
- R6: In special mode the page register accepts every write.
- R7: In normal mode the page register accepts only the first write after reset and ignores later ones. Reset re-arms it.
- R8: dir_addr equals {page, dir_operand}. probe_hit is high exactly when probe_addr[15:8] equals the page.
- R9: Read data is valid in the same cycle as reg_re. It reads 0x00 for unmapped offsets, for unimplemented bits, and while reg_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin | input | 1 | External mode strap, 1 = normal |
| secured | input | 1 | Blocks all mode writes when high |
| reg_addr | input | OFS_W (8) | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read enable |
| reg_rdata | output | 8 | Read data, same cycle |
| dir_operand | input | 8 | Direct-addressing operand |
| dir_addr | output | 16 | Composed direct address |
| probe_addr | input | 16 | Address tested against the page |
| probe_hit | output | 1 | Probe lies in the direct page |
| mode_normal | output | 1 | Current mode, 1 = normal |

## Verification
Mode writes are tried in four patterns: the allowed special-to-normal step, the same-value rewrite, the forbidden normal-to-special request, and any write while secured. Only the allowed step may move the mode bit, and only the forbidden request may raise the lock. Page writes are repeated in special mode and in normal mode, which shows many-write acceptance apart from write-once behaviour. A second reset with the other strap level shows that the lock and the write-once flag are re-armed. The probe is tested with an address inside the page and one just outside it, which separates a true match from a near miss.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  localparam int REG_W    = 8;
  localparam int PG_W     = 8;
  localparam int ADDR_W   = 2 * PG_W;
  localparam int MODE_BIT = 7;
  localparam int LOCK_BIT = 6;

  // Only special(0) -> normal(1) or a same-value write is a legal request.
  function automatic logic mode_move_ok(input logic cur, input logic req);
    return (req == cur) || (!cur && req);
  endfunction

  function automatic logic [ADDR_W-1:0] dp_compose(input logic [PG_W-1:0] page,
                                                   input logic [PG_W-1:0] opnd);
    return {page, opnd};
  endfunction

  function automatic logic dp_in_page(input logic [PG_W-1:0] page,
                                      input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: PG_W] == page;
  endfunction
endpackage

// File: rtl/mdp_mode_reg.sv
module mdp_mode_reg
  import mdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pin,
  input  logic secured,
  input  logic wr_sel,
  input  logic req_bit,
  output logic mode_q,
  output logic lock_q,
  output logic wr_ev,
  output logic illegal_ev
);
  // lock is bypassed while in special mode
  assign wr_ev      = wr_sel && !secured && (!lock_q || !mode_q);
  assign illegal_ev = wr_ev && !mode_move_ok(mode_q, req_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mode_pin;
      lock_q <= 1'b0;
    end else if (wr_ev) begin
      if (illegal_ev) lock_q <= 1'b1;
      else            mode_q <= req_bit;
    end
  end
endmodule

// File: rtl/mdp_dpage_reg.sv
module mdp_dpage_reg
  import mdp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_sel,
  input  logic            mode_normal,
  input  logic [PG_W-1:0] wdata,
  output logic [PG_W-1:0] page_q,
  output logic            once_q,
  output logic            acc_ev
);
  assign acc_ev = wr_sel && (!mode_normal || !once_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      once_q <= 1'b0;
    end else if (acc_ev) begin
      page_q <= wdata;
      if (mode_normal) once_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mdp_rd_mux.sv
module mdp_rd_mux
  import mdp_pkg::*;
#(
  parameter int OFS_W    = 8,
  parameter int MODE_OFS = 'h0B,
  parameter int DP_OFS   = 'h11
) (
  input  logic [OFS_W-1:0] addr,
  input  logic             re,
  input  logic             mode_q,
  input  logic             lock_q,
  input  logic [PG_W-1:0]  page_q,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (re) begin
      if (addr == OFS_W'(MODE_OFS)) begin
        rdata[MODE_BIT] = mode_q;
        rdata[LOCK_BIT] = lock_q;
      end else if (addr == OFS_W'(DP_OFS)) begin
        rdata[PG_W-1:0] = page_q;
      end
    end
  end
endmodule

// File: rtl/mdp_ctrl.sv
module mdp_ctrl
  import mdp_pkg::*;
#(
  parameter int OFS_W    = 8,
  parameter int MODE_OFS = 'h0B,
  parameter int DP_OFS   = 'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic              secured,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PG_W-1:0]   dir_operand,
  output logic [ADDR_W-1:0] dir_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              mode_normal
);
  logic            mode_sel, dp_sel;
  logic            mode_q, lock_q, mode_wr_ev, mode_illegal_ev;
  logic [PG_W-1:0] page_q;
  logic            dp_once, dp_acc_ev;

  assign mode_sel = reg_we && (reg_addr == OFS_W'(MODE_OFS));
  assign dp_sel   = reg_we && (reg_addr == OFS_W'(DP_OFS));

  mdp_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .secured(secured),
    .wr_sel(mode_sel), .req_bit(reg_wdata[MODE_BIT]),
    .mode_q(mode_q), .lock_q(lock_q), .wr_ev(mode_wr_ev), .illegal_ev(mode_illegal_ev)
  );

  mdp_dpage_reg u_page (
    .clk(clk), .rst_n(rst_n), .wr_sel(dp_sel), .mode_normal(mode_q),
    .wdata(reg_wdata[PG_W-1:0]), .page_q(page_q), .once_q(dp_once), .acc_ev(dp_acc_ev)
  );

  mdp_rd_mux #(.OFS_W(OFS_W), .MODE_OFS(MODE_OFS), .DP_OFS(DP_OFS)) u_rd (
    .addr(reg_addr), .re(reg_re), .mode_q(mode_q), .lock_q(lock_q),
    .page_q(page_q), .rdata(reg_rdata)
  );

  assign mode_normal = mode_q;
  assign dir_addr    = dp_compose(page_q, dir_operand);
  assign probe_hit   = dp_in_page(page_q, probe_addr);
endmodule

// File: rtl/mdp_ctrl_chk.sv
module mdp_ctrl_chk
  import mdp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            secured,
  input logic            mode_sel,
  input logic            dp_sel,
  input logic            mode_q,
  input logic            lock_q,
  input logic            mode_illegal_ev,
  input logic            dp_once,
  input logic            dp_acc_ev,
  input logic [PG_W-1:0] page_q,
  input logic [PG_W-1:0] wdata
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst_n;

  // R3
  secured_block_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_d)
    (mode_sel && secured) |=> ($stable(mode_q) && $stable(lock_q)));

  // R2
  mode_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_d)
    !$fell(mode_q));

  // R4
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_d)
    mode_illegal_ev |=> (lock_q && $stable(mode_q)));

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_d)
    lock_q |=> lock_q);

  // R7
  dp_once_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_d)
    (dp_sel && dp_once && mode_q) |=> $stable(page_q));

  // R6
  dp_special_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_d)
    (dp_sel && !mode_q) |=> (page_q == $past(wdata)));

  // R7
  dp_accept_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_d)
    (dp_acc_ev && mode_q) |=> dp_once);
endmodule

bind mdp_ctrl mdp_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .secured(secured), .mode_sel(mode_sel), .dp_sel(dp_sel),
  .mode_q(mode_q), .lock_q(lock_q), .mode_illegal_ev(mode_illegal_ev),
  .dp_once(dp_once), .dp_acc_ev(dp_acc_ev), .page_q(page_q),
  .wdata(reg_wdata[mdp_pkg::PG_W-1:0])
);

// File: tb/mdp_ctrl_tb_top.sv
module mdp_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_MODE = 8'h0B;
  localparam logic [7:0] A_DP   = 8'h11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_pin = 1'b0;
  logic        secured = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [7:0]  reg_rdata;
  logic [7:0]  dir_operand = '0;
  logic [15:0] dir_addr;
  logic [15:0] probe_addr = '0;
  logic        probe_hit;
  logic        mode_normal;

  int check_cnt = 0;
  int fail_cnt  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .secured(secured),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .dir_operand(dir_operand), .dir_addr(dir_addr),
    .probe_addr(probe_addr), .probe_hit(probe_hit), .mode_normal(mode_normal)
  );

  task automatic check_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
    check_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as reads appear
  always @(negedge clk) begin
    if (reg_re && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_val(t, {8'h00, reg_rdata}, {8'h00, e});
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_addr = a; reg_re = 1'b1;
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  task automatic do_reset(input logic pin);
    @(posedge clk); #1;
    rst_n = 1'b0; mode_pin = pin;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_val("R1 mode follows pin in reset", {15'd0, mode_normal}, {15'd0, pin});
    @(posedge clk); #1;
    rst_n = 1'b1;
    mode_pin = ~pin; // pin changes after release must not matter
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", check_cnt, fail_cnt);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check_cnt++; fail_cnt++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    // special-mode start
    do_reset(1'b0);
    bus_read(A_MODE, 8'h00, "R1 mode captured special");
    bus_read(A_DP, 8'h00, "R5 page reset value");
    // R6 repeated page writes in special mode
    bus_write(A_DP, 8'h12);
    bus_read(A_DP, 8'h12, "R6 special page write 1");
    bus_write(A_DP, 8'h34);
    bus_read(A_DP, 8'h34, "R6 special page write 2");
    // R3 secured blocks the legal step
    secured = 1'b1;
    bus_write(A_MODE, 8'h80);
    bus_read(A_MODE, 8'h00, "R3 secured mode write ignored");
    secured = 1'b0;
    // R2 same-value write, then the legal step, then same value again
    bus_write(A_MODE, 8'h00);
    bus_read(A_MODE, 8'h00, "R2 same-value special write");
    bus_write(A_MODE, 8'h80);
    bus_read(A_MODE, 8'h80, "R2 special to normal accepted");
    bus_write(A_MODE, 8'hFF);
    bus_read(A_MODE, 8'h80, "R2 same-value normal write no lock");
    // R7 write-once in normal mode
    bus_write(A_DP, 8'h56);
    bus_read(A_DP, 8'h56, "R7 first normal page write");
    bus_write(A_DP, 8'h78);
    bus_read(A_DP, 8'h56, "R7 second normal page write ignored");
    // R4 illegal request locks
    bus_write(A_MODE, 8'h00);
    bus_read(A_MODE, 8'hC0, "R4 illegal request locks");
    bus_write(A_MODE, 8'h00);
    bus_read(A_MODE, 8'hC0, "R4 lock sticky");
    // R8 address composition and probe
    @(posedge clk); #1;
    dir_operand = 8'hAB; probe_addr = 16'h56FF;
    @(negedge clk);
    check_val("R8 dir_addr", dir_addr, 16'h56AB);
    check_val("R8 probe inside page", {15'd0, probe_hit}, 16'd1);
    @(posedge clk); #1;
    probe_addr = 16'h5700;
    @(negedge clk);
    check_val("R8 probe outside page", {15'd0, probe_hit}, 16'd0);
    // R9 unmapped offset and read-enable low
    bus_read(8'h10, 8'h00, "R9 unmapped offset");
    @(posedge clk); #1;
    reg_addr = A_DP;
    @(negedge clk);
    check_val("R9 rdata zero without re", {8'h00, reg_rdata}, 16'h0000);
    // second reset, pin normal: lock and write-once re-armed
    do_reset(1'b1);
    bus_read(A_MODE, 8'h80, "R1 mode captured normal, R4 lock cleared");
    bus_read(A_DP, 8'h00, "R5 page reset again");
    bus_write(A_DP, 8'h9A);
    bus_read(A_DP, 8'h9A, "R7 write-once re-armed by reset");
    bus_write(A_DP, 8'hBC);
    bus_read(A_DP, 8'h9A, "R7 second write ignored again");
    @(posedge clk); #1;
    dir_operand = 8'h01;
    @(negedge clk);
    check_val("R8 dir_addr after reset", dir_addr, 16'h9A01);
    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule